// File: doc/BRIEF.md
# Serial Host Register Bridge

This block lets an external host reach a small processor over a four-wire serial link in which the host is the master. It runs entirely on the host's serial clock. Every frame addresses one of six byte-wide registers. Two of the registers mirror the processor's parallel ports: one drives a port input and the other reads back a port output. One register drives the processor's control pins, including the boot-mode selection. One is a read-only status byte. The last two form a byte mailbox in each direction.

The block does not move the mailbox bytes across to the processor's clock. It presents the written byte together with a one-cycle write strobe, and it gives a one-cycle read-done strobe when the host has shifted out the returned byte. A separate synchronizer and handshake stage, clocked by the processor, consumes these strobes.

Top module: `spi_regbank`

## Requirements
- R1: A frame starts when `spi_cs_n` goes low (active low) and has 16 bits, most significant first. The first bit is the direction (1 = write, 0 = read), the next 7 bits are the register address and the last 8 bits are data. `spi_mosi` is sampled on rising `spi_clk`. `spi_miso` changes on falling `spi_clk` and carries the read byte during the 8 data bits of the same frame. It is 0 during the header.
- R2: A write to address 0 sets `port0_out`. A read of address 0 returns the stored value.
- R3: A read of address 1 returns the value that `port1_in` has when the data phase begins.
- R4: A write to address 2 sets `ctrl_out`, whose bits 1:0 are the boot-mode field. A read of address 2 returns the stored value.
- R5: A read of address 3 returns `{4'b0000, stat_in}`: bit 3 is read-pending, bit 2 is write-pending, bit 1 is input-FIFO full and bit 0 is input-FIFO empty.
- R6: A write to address 4 sets `tx_byte`. `tx_stb` is high for exactly the one `spi_clk` cycle after the rising edge that samples the last data bit. A read of address 4 returns the stored value.
- R7: A read of address 5 returns `rx_byte`. `rx_done` is high for exactly the one `spi_clk` cycle after the rising edge that samples the last data bit.
- R8: Writes to addresses 1, 3 and 5 and to addresses 6..127 change no register and raise no strobe. Reads of addresses 6..127 return 0x00.
- R9: A frame in which `spi_cs_n` rises before the 16th bit changes no register and raises no strobe.
- R10: While `rst_n` is low, all written registers read as 0x00, `spi_miso` is 0 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_clk | input | 1 | Host serial clock |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| port0_out | output | 8 | Drives processor parallel port 0 input |
| port1_in | input | 8 | Processor parallel port 1 output |
| ctrl_out | output | 8 | Processor control pins, bits 1:0 boot mode |
| stat_in | input | 4 | Status flags: read-pending, write-pending, FIFO full, FIFO empty |
| tx_byte | output | 8 | Mailbox byte toward processor |
| tx_stb | output | 1 | One-cycle pulse when `tx_byte` is written |
| rx_byte | input | 8 | Mailbox byte from processor |
| rx_done | output | 1 | One-cycle pulse when `rx_byte` has been read |

## Verification
Some properties can be checked on every clock. The assertions check them: each strobe is a single-cycle pulse, the two strobes are never high together, and neither strobe follows a cycle with select high. They also check that the port, control and mailbox registers change only while a frame is active, and that the mailbox byte changes only together with its strobe. Other behaviour depends on a frame's content, so only the bench scenarios can show it. That covers correct bit order and address decode, read-back data on the output line, status bit positions, writes that must be ignored for read-only and unmapped addresses, and frames cut off at several bit counts.

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          rst_n,
  input  logic          spi_clk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic [DW-1:0] port0_out,
  input  logic [DW-1:0] port1_in,
  output logic [DW-1:0] ctrl_out,
  input  logic [3:0]    stat_in,
  output logic [DW-1:0] tx_byte,
  output logic          tx_stb,
  input  logic [DW-1:0] rx_byte,
  output logic          rx_done
);
  localparam int FW = 1 + AW + DW;
  localparam int CW = $clog2(FW + 1);
  localparam int SW = (AW > DW - 1) ? AW : DW - 1;

  logic [CW-1:0] cnt;
  logic [SW-1:0] sh;
  logic          wr;
  logic [AW-1:0] adr;
  logic [DW-1:0] rdv, osh;

  wire          last     = !spi_cs_n && cnt == CW'(FW - 1);
  wire          hdr_done = !spi_cs_n && cnt == CW'(AW);
  wire [DW-1:0] wdat     = {sh[DW-2:0], spi_mosi};

  always_ff @(posedge spi_clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; sh <= '0; wr <= 1'b0; adr <= '0;
    end else if (spi_cs_n) begin
      cnt <= '0;
    end else begin
      sh <= {sh[SW-2:0], spi_mosi};
      if (cnt != CW'(FW)) cnt <= cnt + 1'b1;
      if (hdr_done) {wr, adr} <= {sh[AW-1:0], spi_mosi};
    end

  always_ff @(posedge spi_clk or negedge rst_n)
    if (!rst_n) begin
      port0_out <= '0; ctrl_out <= '0; tx_byte <= '0;
      tx_stb <= 1'b0; rx_done <= 1'b0;
    end else begin
      tx_stb  <= 1'b0;
      rx_done <= 1'b0;
      if (last && wr)
        case (adr)
          AW'(0): port0_out <= wdat;
          AW'(2): ctrl_out  <= wdat;
          AW'(4): begin tx_byte <= wdat; tx_stb <= 1'b1; end
          default: ;
        endcase
      if (last && !wr && adr == AW'(5)) rx_done <= 1'b1;
    end

  always_comb
    case (adr)
      AW'(0):  rdv = port0_out;
      AW'(1):  rdv = port1_in;
      AW'(2):  rdv = ctrl_out;
      AW'(3):  rdv = {{(DW-4){1'b0}}, stat_in};
      AW'(4):  rdv = tx_byte;
      AW'(5):  rdv = rx_byte;
      default: rdv = '0;
    endcase

  always_ff @(negedge spi_clk or negedge rst_n)
    if (!rst_n)                                        osh <= '0;
    else if (spi_cs_n)                                 osh <= '0;
    else if (cnt == CW'(AW + 1))                       osh <= wr ? '0 : rdv;
    else if (cnt > CW'(AW + 1) && cnt < CW'(FW))       osh <= {osh[DW-2:0], 1'b0};

  assign spi_miso = osh[DW-1];
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
  parameter int DW = 8
) (
  input logic          rst_n,
  input logic          spi_clk,
  input logic          spi_cs_n,
  input logic [DW-1:0] port0_out,
  input logic [DW-1:0] ctrl_out,
  input logic [DW-1:0] tx_byte,
  input logic          tx_stb,
  input logic          rx_done
);
  a_r6_tx_stb_single: assert property (@(posedge spi_clk) disable iff (!rst_n)
    tx_stb |=> !tx_stb);
  a_r7_rx_done_single: assert property (@(posedge spi_clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  a_r8_strobes_exclusive: assert property (@(posedge spi_clk) disable iff (!rst_n)
    !(tx_stb && rx_done));
  a_r9_no_strobe_when_idle: assert property (@(posedge spi_clk) disable iff (!rst_n)
    spi_cs_n |=> (!tx_stb && !rx_done));
  a_r6_tx_moves_with_strobe: assert property (@(posedge spi_clk) disable iff (!rst_n)
    !$stable(tx_byte) |-> tx_stb);
  a_r2_port0_only_in_frame: assert property (@(posedge spi_clk) disable iff (!rst_n)
    !$stable(port0_out) |-> $past(!spi_cs_n));
  a_r4_ctrl_only_in_frame: assert property (@(posedge spi_clk) disable iff (!rst_n)
    !$stable(ctrl_out) |-> $past(!spi_cs_n));
endmodule

bind spi_regbank spi_regbank_chk #(.DW(DW)) chk (
  .rst_n(rst_n), .spi_clk(spi_clk), .spi_cs_n(spi_cs_n),
  .port0_out(port0_out), .ctrl_out(ctrl_out), .tx_byte(tx_byte),
  .tx_stb(tx_stb), .rx_done(rx_done)
);

// File: tb/spi_regbank_test.sv
module spi_regbank_test;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, tx_stb, rx_done;
  logic [7:0] port0_out, ctrl_out, tx_byte;
  logic [7:0] port1_in = 8'h00, rx_byte = 8'h00;
  logic [3:0] stat_in = 4'h0;
  int total = 0, bad = 0;

  typedef struct { logic [7:0] v; int req; } item_t;
  item_t exp_q[$], act_q[$];

  always #2.5 clk = ~clk;

  spi_regbank uut (
    .rst_n(rst_n), .spi_clk(clk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .port0_out(port0_out), .port1_in(port1_in), .ctrl_out(ctrl_out), .stat_in(stat_in),
    .tx_byte(tx_byte), .tx_stb(tx_stb), .rx_byte(rx_byte), .rx_done(rx_done)
  );

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      item_t a, e;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      check(e.req, a.v, e.v);
    end
  end

  task automatic frame(input bit rw, input logic [6:0] a, input logic [7:0] d,
                       input int nbits, input bit etx, input bit erx, output logic [7:0] rd);
    logic [15:0] f;
    logic [7:0] hdr;
    f = {rw, a, d};
    rd = 8'h00;
    hdr = 8'h00;
    @(posedge clk); #1 cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = f[15-i];
      @(negedge clk); #1;
      if (i >= 8) rd[15-i] = miso;
      else hdr[7-i] = miso;
      @(posedge clk); #1;
    end
    cs_n = 1'b1;
    check(1, hdr, 8'h00);               // R1 header quiet
    check(6, {7'b0, tx_stb}, {7'b0, etx}); // R6 / R9 strobe
    check(7, {7'b0, rx_done}, {7'b0, erx}); // R7 / R9 strobe
    @(posedge clk); #1;
    check(6, {6'b0, tx_stb, rx_done}, 8'h00); // R6 R7 single cycle
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] rd;
    frame(1'b1, a, d, 16, a == 7'd4, 1'b0, rd);
  endtask

  task automatic rdchk(input logic [6:0] a, input logic [7:0] e, input int req);
    logic [7:0] rd;
    item_t x;
    frame(1'b0, a, 8'h00, 16, 1'b0, a == 7'd5, rd);
    x.v = e;  x.req = req; exp_q.push_back(x);
    x.v = rd; x.req = req; act_q.push_back(x);
  endtask

  initial begin
    logic [7:0] rd;
    #1;
    check(10, port0_out, 8'h00); // R10
    check(10, ctrl_out, 8'h00);  // R10
    check(10, tx_byte, 8'h00);   // R10
    check(10, {5'b0, miso, tx_stb, rx_done}, 8'h00); // R10
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    wr(7'd0, 8'hA5); check(2, port0_out, 8'hA5); // R2
    rdchk(7'd0, 8'hA5, 2);                       // R2 R1
    wr(7'd0, 8'h01); check(2, port0_out, 8'h01); // R2 bit order

    port1_in = 8'h3C; rdchk(7'd1, 8'h3C, 3);     // R3
    port1_in = 8'hC3; rdchk(7'd1, 8'hC3, 3);     // R3

    wr(7'd2, 8'h02); check(4, {6'b0, ctrl_out[1:0]}, 8'h02); // R4 boot mode
    wr(7'd2, 8'h83); check(4, ctrl_out, 8'h83);              // R4
    rdchk(7'd2, 8'h83, 4);                                   // R4

    stat_in = 4'b1010; rdchk(7'd3, 8'h0A, 5);    // R5
    stat_in = 4'b0101; rdchk(7'd3, 8'h05, 5);    // R5
    wr(7'd3, 8'hFF); rdchk(7'd3, 8'h05, 5);      // R5 R8 read-only

    wr(7'd4, 8'h5E); check(6, tx_byte, 8'h5E);   // R6
    rdchk(7'd4, 8'h5E, 6);                       // R6

    rx_byte = 8'h96; rdchk(7'd5, 8'h96, 7);      // R7
    rx_byte = 8'h69; rdchk(7'd5, 8'h69, 7);      // R7

    wr(7'd1, 8'h77); rdchk(7'd1, 8'hC3, 8);      // R8
    wr(7'd5, 8'h77); rdchk(7'd5, 8'h69, 8);      // R8
    wr(7'd6, 8'h11); wr(7'h40, 8'h22); wr(7'h7F, 8'h33); // R8 unmapped
    check(8, port0_out, 8'h01); check(8, ctrl_out, 8'h83); check(8, tx_byte, 8'h5E); // R8
    rdchk(7'd6, 8'h00, 8); rdchk(7'h7F, 8'h00, 8); rdchk(7'h40, 8'h00, 8); // R8

    frame(1'b1, 7'd0, 8'hEE, 15, 1'b0, 1'b0, rd); // R9
    frame(1'b1, 7'd0, 8'hEE, 9, 1'b0, 1'b0, rd);  // R9
    frame(1'b1, 7'd4, 8'hEE, 15, 1'b0, 1'b0, rd); // R9
    frame(1'b0, 7'd5, 8'h00, 15, 1'b0, 1'b0, rd); // R9 no read-done
    check(9, port0_out, 8'h01); check(9, tx_byte, 8'h5E); // R9
    wr(7'd0, 8'h5A); check(9, port0_out, 8'h5A);          // R9 recovers

    repeat (4) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule